// File: doc/BRIEF.md
# I2C Slave Register Bridge

This block is a two-wire serial slave that gives an external host byte-wide read and write access to a 16-bit internal address space. It watches the clock and data lines, recognises frame delimiters, and answers to one 7-bit device identity. The upper four bits of that identity are a build-time constant. The lower three come from strap inputs, so several copies can share one bus.

After a write-direction device byte, the host sends a register address, high byte first. Every data byte that follows becomes a one-cycle write on a simple synchronous register port toward the internal memory, and the address steps by one after each byte. A read-direction device byte makes the block fetch a byte through the same port and shift it out MSB first. The block keeps fetching consecutive addresses for as long as the host acknowledges. A random read is a write frame that carries only the address, followed by a repeated START with the read bit.

Both bus lines pass through two-flop synchronisers on the system clock. The system clock must run several times faster than the serial clock. The data line is driven only as an open-drain pull-down, through `sdaOe`.

Top module: `i2c_reg_bridge`

## Requirements
- R1: A START (data falls while clock is high) restarts frame decoding from any state and drops a partly received byte without any port write. A STOP (data rises while clock is high) returns the block to idle with the data line released.
- R2: The device byte is received MSB first. Its upper seven bits must equal {DEV_HI, strap} and its bit 0 gives the direction (0 write, 1 read). On a match the block pulls data low during the ninth clock. Otherwise it gives no acknowledge and ignores the bus until the next START.
- R3: In a write frame, the two bytes after the device byte load the register address, high byte first, and each is acknowledged.
- R4: Each further write-frame byte is acknowledged and produces a single-cycle `regWr` pulse with `regAddr` set to the current address and `regWdata` set to the byte.
- R5: The address steps by one after every written or read byte and wraps from 0xFFFF to 0x0000.
- R6: A read issues a single-cycle `regRd` pulse and captures `regRdata` in the following cycle. The byte is then shifted out MSB first, and the data line changes only while the serial clock is low.
- R7: While the host acknowledges a read byte, the next consecutive address is fetched and sent. On a host not-acknowledge the block releases the data line and drives nothing until the next START.
- R8: A repeated START keeps the loaded address, so a read right after an address-only write frame starts at that address. A later read frame continues from the address after the last byte transferred.
- R9: After reset `sdaOe`, `regWr` and `regRd` are low.
- R10: `regWr` and `regRd` are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low asynchronous reset |
| sclIn | input | 1 | Serial clock line level |
| sdaIn | input | 1 | Serial data line level |
| strap | input | 3 | Low bits of the device identity |
| sdaOe | output | 1 | 1 pulls the data line low |
| regAddr | output | 16 | Register port address |
| regWdata | output | 8 | Register port write data |
| regWr | output | 1 | Single-cycle write strobe |
| regRd | output | 1 | Single-cycle read strobe |
| regRdata | input | 8 | Read data, valid the cycle after `regRd` |

## Verification
The bench sweeps all eight low identity values against a fixed strap and also sends a wrong upper identity. A comparator with an off-by-one bit field or without the strap would acknowledge the wrong one. Sequential writes and reads are started just below 0xFFFF so that the address must wrap, which catches a counter that carries into a wider register or saturates. A byte cut short by a repeated START must produce no write. After a read ends with not-acknowledge, the bench clocks the bus further and checks that the block drives nothing: a design that kept sending would show zeros. A read frame after a STOP must resume at the next address, so a design that reloads or loses the counter across frames is caught.

// File: rtl/i2c_bridge_pkg.sv
package i2c_bridge_pkg;

  typedef struct packed {
    logic shiftRx;
    logic loadHi;
    logic loadLo;
    logic wrStb;
    logic rdStb;
    logic shiftTx;
  } ctlStb_t;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_DEV,
    ST_AHI,
    ST_ALO,
    ST_WDAT,
    ST_ACK,
    ST_TX,
    ST_HACK
  } busState_t;

endpackage

// File: rtl/i2c_bridge_dp.sv
module i2c_bridge_dp
  import i2c_bridge_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  sclIn,
  input  logic                  sdaIn,
  input  ctlStb_t               stb,
  output logic                  sclLvl,
  output logic                  sdaLvl,
  output logic                  sclRise,
  output logic                  sclFall,
  output logic                  startEv,
  output logic                  stopEv,
  output logic [DATA_W-1:0]     rxByte,
  output logic [1:0]            txTop,
  output logic [2*DATA_W-1:0]   regAddr,
  output logic [DATA_W-1:0]     regWdata,
  output logic                  regWr,
  output logic                  regRd,
  input  logic [DATA_W-1:0]     regRdata
);
  localparam int ADDR_W = 2 * DATA_W;

  logic [1:0]        sclSync, sdaSync;
  logic              sclPrev, sdaPrev;
  logic [DATA_W-1:0] rxSh, txSh;
  logic [ADDR_W-1:0] addrCnt;
  logic              rdPend;

  assign sclLvl  = sclSync[1];
  assign sdaLvl  = sdaSync[1];
  assign sclRise = sclLvl & ~sclPrev;
  assign sclFall = ~sclLvl & sclPrev;
  assign startEv = sclLvl & sclPrev & sdaPrev & ~sdaLvl;
  assign stopEv  = sclLvl & sclPrev & ~sdaPrev & sdaLvl;
  assign rxByte  = rxSh;
  assign txTop   = txSh[DATA_W-1 -: 2];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sclSync <= 2'b11;
      sdaSync <= 2'b11;
      sclPrev <= 1'b1;
      sdaPrev <= 1'b1;
    end else begin
      sclSync <= {sclSync[0], sclIn};
      sdaSync <= {sdaSync[0], sdaIn};
      sclPrev <= sclLvl;
      sdaPrev <= sdaLvl;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rxSh     <= '0;
      txSh     <= '0;
      addrCnt  <= '0;
      regAddr  <= '0;
      regWdata <= '0;
      regWr    <= 1'b0;
      regRd    <= 1'b0;
      rdPend   <= 1'b0;
    end else begin
      regWr  <= stb.wrStb;
      regRd  <= stb.rdStb;
      rdPend <= regRd;
      if (stb.shiftRx) rxSh <= {rxSh[DATA_W-2:0], sdaLvl};
      if (stb.loadHi) addrCnt[ADDR_W-1 -: DATA_W] <= rxSh;
      if (stb.loadLo) addrCnt[DATA_W-1:0] <= rxSh;
      if (stb.wrStb || stb.rdStb) begin
        regAddr <= addrCnt;
        addrCnt <= addrCnt + ADDR_W'(1);
      end
      if (stb.wrStb) regWdata <= rxSh;
      if (rdPend) txSh <= regRdata;
      else if (stb.shiftTx) txSh <= {txSh[DATA_W-2:0], 1'b0};
    end
  end

  AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (!rstN)
    !(regWr && regRd)); // R10
  AST_WR_SINGLE: assert property (@(posedge clk) disable iff (!rstN)
    regWr |=> !regWr); // R4
  AST_RD_SINGLE: assert property (@(posedge clk) disable iff (!rstN)
    regRd |=> !regRd); // R6
endmodule

// File: rtl/i2c_bridge_ctl.sv
module i2c_bridge_ctl
  import i2c_bridge_pkg::*;
#(
  parameter int DATA_W   = 8,
  parameter int DEV_HI_W = 4,
  parameter logic [DEV_HI_W-1:0] DEV_HI = 4'b1010
) (
  input  logic                         clk,
  input  logic                         rstN,
  input  logic                         sclLvl,
  input  logic                         sdaLvl,
  input  logic                         sclRise,
  input  logic                         sclFall,
  input  logic                         startEv,
  input  logic                         stopEv,
  input  logic [DATA_W-1:0]            rxByte,
  input  logic [1:0]                   txTop,
  input  logic [DATA_W-2-DEV_HI_W:0]   strap,
  output ctlStb_t                      stb,
  output logic                         sdaOe
);
  localparam int BIT_W = $clog2(DATA_W + 1);

  busState_t         state, stateN, nextSt, nextN;
  logic [BIT_W-1:0]  bitCnt, bitN;
  logic              oeN, hostAcked, ackdN;

  always_comb begin
    stateN = state;
    nextN  = nextSt;
    bitN   = bitCnt;
    oeN    = sdaOe;
    ackdN  = hostAcked;
    stb    = '0;
    if (stopEv) begin
      stateN = ST_IDLE;
      oeN    = 1'b0;
    end else if (startEv) begin
      stateN = ST_DEV;
      bitN   = '0;
      oeN    = 1'b0;
    end else begin
      case (state)
        ST_DEV, ST_AHI, ST_ALO, ST_WDAT: begin
          if (sclRise && bitCnt != BIT_W'(DATA_W)) begin
            stb.shiftRx = 1'b1;
            bitN = bitCnt + BIT_W'(1);
          end else if (sclFall && bitCnt == BIT_W'(DATA_W)) begin
            oeN    = 1'b1;
            stateN = ST_ACK;
            case (state)
              ST_DEV: begin
                if (rxByte[DATA_W-1:1] == {DEV_HI, strap}) begin
                  if (rxByte[0]) begin
                    stb.rdStb = 1'b1;
                    nextN = ST_TX;
                  end else begin
                    nextN = ST_AHI;
                  end
                end else begin
                  oeN    = 1'b0;
                  stateN = ST_IDLE;
                end
              end
              ST_AHI: begin
                stb.loadHi = 1'b1;
                nextN = ST_ALO;
              end
              ST_ALO: begin
                stb.loadLo = 1'b1;
                nextN = ST_WDAT;
              end
              default: begin
                stb.wrStb = 1'b1;
                nextN = ST_WDAT;
              end
            endcase
          end
        end
        ST_ACK: begin
          if (sclFall) begin
            bitN   = '0;
            stateN = nextSt;
            oeN    = (nextSt == ST_TX) ? ~txTop[1] : 1'b0;
          end
        end
        ST_TX: begin
          if (sclFall) begin
            if (bitCnt == BIT_W'(DATA_W - 1)) begin
              oeN    = 1'b0;
              ackdN  = 1'b0;
              stateN = ST_HACK;
            end else begin
              stb.shiftTx = 1'b1;
              oeN  = ~txTop[0];
              bitN = bitCnt + BIT_W'(1);
            end
          end
        end
        ST_HACK: begin
          if (sclRise) begin
            if (!sdaLvl) begin
              ackdN     = 1'b1;
              stb.rdStb = 1'b1;
            end else begin
              stateN = ST_IDLE;
            end
          end else if (sclFall && hostAcked) begin
            oeN    = ~txTop[1];
            bitN   = '0;
            stateN = ST_TX;
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state     <= ST_IDLE;
      nextSt    <= ST_IDLE;
      bitCnt    <= '0;
      sdaOe     <= 1'b0;
      hostAcked <= 1'b0;
    end else begin
      state     <= stateN;
      nextSt    <= nextN;
      bitCnt    <= bitN;
      sdaOe     <= oeN;
      hostAcked <= ackdN;
    end
  end

  AST_IDLE_RELEASED: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_IDLE) |-> !sdaOe); // R1
  AST_OE_SCL_LOW: assert property (@(posedge clk) disable iff (!rstN)
    (sdaOe != $past(sdaOe)) |-> !sclLvl); // R6
  AST_HACK_RELEASED: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_HACK) |-> !sdaOe); // R7
endmodule

// File: rtl/i2c_reg_bridge.sv
module i2c_reg_bridge
  import i2c_bridge_pkg::*;
#(
  parameter int DATA_W   = 8,
  parameter int DEV_HI_W = 4,
  parameter logic [DEV_HI_W-1:0] DEV_HI = 4'b1010
) (
  input  logic                         clk,
  input  logic                         rstN,
  input  logic                         sclIn,
  input  logic                         sdaIn,
  input  logic [DATA_W-2-DEV_HI_W:0]   strap,
  output logic                         sdaOe,
  output logic [2*DATA_W-1:0]          regAddr,
  output logic [DATA_W-1:0]            regWdata,
  output logic                         regWr,
  output logic                         regRd,
  input  logic [DATA_W-1:0]            regRdata
);
  ctlStb_t           stb;
  logic              sclLvl, sdaLvl, sclRise, sclFall, startEv, stopEv;
  logic [DATA_W-1:0] rxByte;
  logic [1:0]        txTop;

  i2c_bridge_dp #(.DATA_W(DATA_W)) dp_i (
    .clk(clk), .rstN(rstN), .sclIn(sclIn), .sdaIn(sdaIn), .stb(stb),
    .sclLvl(sclLvl), .sdaLvl(sdaLvl), .sclRise(sclRise), .sclFall(sclFall),
    .startEv(startEv), .stopEv(stopEv), .rxByte(rxByte), .txTop(txTop),
    .regAddr(regAddr), .regWdata(regWdata), .regWr(regWr), .regRd(regRd),
    .regRdata(regRdata)
  );

  i2c_bridge_ctl #(.DATA_W(DATA_W), .DEV_HI_W(DEV_HI_W), .DEV_HI(DEV_HI)) ctl_i (
    .clk(clk), .rstN(rstN), .sclLvl(sclLvl), .sdaLvl(sdaLvl),
    .sclRise(sclRise), .sclFall(sclFall), .startEv(startEv), .stopEv(stopEv),
    .rxByte(rxByte), .txTop(txTop), .strap(strap), .stb(stb), .sdaOe(sdaOe)
  );
endmodule

// File: tb/i2c_reg_bridge_tb_top.sv
module i2c_reg_bridge_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int HALF = 6;
  localparam logic [2:0] STRAP = 3'b101;
  localparam logic [3:0] IDHI = 4'b1010;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic sclDrv = 1'b1;
  logic hostSda = 1'b1;
  logic sdaOe, regWr, regRd;
  logic [15:0] regAddr;
  logic [7:0] regWdata, rdq;
  logic sdaLine;

  int total = 0;
  int bad = 0;
  int wCnt = 0;
  logic [15:0] wAddr [0:15];
  logic [7:0]  wData [0:15];

  assign sdaLine = hostSda & ~sdaOe;

  always #(CLK_PERIOD/2) clk = ~clk;

  i2c_reg_bridge dut_i (
    .clk(clk), .rstN(rstN), .sclIn(sclDrv), .sdaIn(sdaLine), .strap(STRAP),
    .sdaOe(sdaOe), .regAddr(regAddr), .regWdata(regWdata), .regWr(regWr),
    .regRd(regRd), .regRdata(rdq)
  );

  function automatic logic [7:0] rdVal(input logic [15:0] a);
    return a[15:8] ^ a[7:0] ^ 8'h5A;
  endfunction

  always @(posedge clk) if (regRd) rdq <= rdVal(regAddr);

  always @(negedge clk) if (rstN && regWr) begin
    if (wCnt < 16) begin
      wAddr[wCnt] = regAddr;
      wData[wCnt] = regWdata;
    end
    wCnt = wCnt + 1;
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic waitH();
    repeat (HALF) @(negedge clk);
  endtask

  task automatic startC();
    hostSda = 1'b1; waitH();
    sclDrv = 1'b1; waitH();
    hostSda = 1'b0; waitH();
    sclDrv = 1'b0; waitH();
  endtask

  task automatic stopC();
    hostSda = 1'b0; waitH();
    sclDrv = 1'b1; waitH();
    hostSda = 1'b1; waitH();
  endtask

  task automatic sendBits(input logic [7:0] b, input int n);
    for (int i = 7; i > 7 - n; i--) begin
      hostSda = b[i]; waitH();
      sclDrv = 1'b1; waitH();
      sclDrv = 1'b0;
    end
  endtask

  task automatic wrByte(input logic [7:0] b, output bit ack);
    sendBits(b, 8);
    hostSda = 1'b1; waitH();
    sclDrv = 1'b1; repeat (HALF/2) @(negedge clk);
    ack = (sdaLine == 1'b0);
    repeat (HALF/2) @(negedge clk);
    sclDrv = 1'b0;
  endtask

  task automatic rdByte(input bit giveAck, output logic [7:0] b);
    hostSda = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      waitH();
      sclDrv = 1'b1; repeat (HALF/2) @(negedge clk);
      b[i] = sdaLine;
      repeat (HALF/2) @(negedge clk);
      sclDrv = 1'b0;
    end
    hostSda = giveAck ? 1'b0 : 1'b1; waitH();
    sclDrv = 1'b1; waitH();
    sclDrv = 1'b0;
    hostSda = 1'b1;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog actual=%h expected=%h", 0, 1);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    bit ack;
    logic [7:0] b;
    int w0;
    logic [7:0] devW, devR;
    devW = {IDHI, STRAP, 1'b0};
    devR = {IDHI, STRAP, 1'b1};
    repeat (4) @(negedge clk);
    chk(sdaOe == 1'b0, "R9 sdaOe", 32'(sdaOe), 0);
    chk(regWr == 1'b0, "R9 regWr", 32'(regWr), 0);
    chk(regRd == 1'b0, "R9 regRd", 32'(regRd), 0);
    rstN = 1'b1;
    repeat (4) @(negedge clk);

    // R2: sweep low identity bits, one wrong upper identity
    for (int s = 0; s < 8; s++) begin
      startC();
      wrByte({IDHI, 3'(s), 1'b0}, ack);
      stopC();
      chk(ack == (s == int'(STRAP)), "R2 identity sweep ack", 32'(ack), 32'(s == int'(STRAP)));
    end
    startC();
    wrByte({4'b0110, STRAP, 1'b0}, ack);
    chk(!ack, "R2 wrong upper identity", 32'(ack), 0);
    wrByte(8'h00, ack);
    chk(!ack, "R2 ignored after mismatch", 32'(ack), 0);
    stopC();
    chk(wCnt == 0, "R2 no port write", 32'(wCnt), 0);

    // R3 R4: single byte write
    startC();
    wrByte(devW, ack);  chk(ack, "R2 device ack", 32'(ack), 1);
    wrByte(8'h12, ack); chk(ack, "R3 addr high ack", 32'(ack), 1);
    wrByte(8'h34, ack); chk(ack, "R3 addr low ack", 32'(ack), 1);
    wrByte(8'hA5, ack); chk(ack, "R4 data ack", 32'(ack), 1);
    stopC();
    chk(wCnt == 1, "R4 write count", 32'(wCnt), 1);
    chk(wAddr[0] == 16'h1234, "R3 write address", 32'(wAddr[0]), 32'h1234);
    chk(wData[0] == 8'hA5, "R4 write data", 32'(wData[0]), 32'hA5);

    // R5: sequential write across the wrap
    w0 = wCnt;
    startC();
    wrByte(devW, ack); wrByte(8'hFF, ack); wrByte(8'hFE, ack);
    for (int i = 0; i < 4; i++) begin
      wrByte(8'(8'h10 + i), ack);
      chk(ack, "R4 sequential data ack", 32'(ack), 1);
    end
    stopC();
    chk(wCnt == w0 + 4, "R5 sequential count", 32'(wCnt), 32'(w0 + 4));
    for (int i = 0; i < 4; i++) begin
      chk(wAddr[w0+i] == 16'(16'hFFFE + i), "R5 wrap address", 32'(wAddr[w0+i]), 32'(16'(16'hFFFE + i)));
      chk(wData[w0+i] == 8'(8'h10 + i), "R4 sequential data", 32'(wData[w0+i]), 32'(8'h10 + i));
    end

    // R1: byte cut short by repeated START makes no write
    w0 = wCnt;
    startC();
    wrByte(devW, ack); wrByte(8'h20, ack); wrByte(8'h00, ack);
    sendBits(8'hC3, 4);
    startC();
    wrByte(devW, ack); wrByte(8'h30, ack); wrByte(8'h00, ack); wrByte(8'h77, ack);
    stopC();
    chk(wCnt == w0 + 1, "R1 partial byte dropped", 32'(wCnt), 32'(w0 + 1));
    chk(wAddr[w0] == 16'h3000 && wData[w0] == 8'h77, "R1 frame after restart",
        {wAddr[w0], 8'h00, wData[w0]}, 32'h3000_0077);

    // R8 R6 R7: random read with repeated START
    startC();
    wrByte(devW, ack); wrByte(8'hAB, ack); wrByte(8'hCD, ack);
    startC();
    wrByte(devR, ack); chk(ack, "R2 read device ack", 32'(ack), 1);
    for (int i = 0; i < 3; i++) begin
      rdByte(i != 2, b);
      chk(b == rdVal(16'(16'hABCD + i)), "R6 R8 sequential read data", 32'(b), 32'(rdVal(16'(16'hABCD + i))));
    end
    repeat (4) @(negedge clk);
    chk(sdaOe == 1'b0, "R7 released after nack", 32'(sdaOe), 0);
    rdByte(1'b0, b);
    chk(b == 8'hFF, "R7 silent after nack", 32'(b), 32'hFF);
    stopC();

    // R8: read frame resumes at next address
    startC();
    wrByte(devR, ack);
    rdByte(1'b0, b);
    stopC();
    chk(b == rdVal(16'hABD0), "R8 resume address", 32'(b), 32'(rdVal(16'hABD0)));

    // R5 R7: read across the wrap
    startC();
    wrByte(devW, ack); wrByte(8'hFF, ack); wrByte(8'hFF, ack);
    startC();
    wrByte(devR, ack);
    rdByte(1'b1, b);
    chk(b == rdVal(16'hFFFF), "R6 read at top", 32'(b), 32'(rdVal(16'hFFFF)));
    rdByte(1'b0, b);
    chk(b == rdVal(16'h0000), "R5 read wrap", 32'(b), 32'(rdVal(16'h0000)));
    stopC();
    repeat (4) @(negedge clk);
    chk(sdaOe == 1'b0, "R1 idle after stop", 32'(sdaOe), 0);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule